// File: doc/BRIEF.md
# Sector Error-Location Corrector

This block runs after a 4-error-per-sector syndrome engine and repairs a 512-byte sector that is held in a local RAM. A one-cycle start pulse launches a job. The block then screens the ten stored ECC bytes and the syndrome words. An erased sector or a zero syndrome ends the job at once. Otherwise the block sends a one-cycle request to the engine to compute error locations, and it watches the engine's 4-bit status code until that code settles.

When locations are ready, the block walks through the reported errors one at a time. It unpacks each address/value pair from two packed 32-bit words and turns the 10-bit location, which counts back from the end of a 519-byte codeword, into a byte index. For each hit inside the data area it performs a read-modify-write on the RAM. It ends with a one-cycle done or uncorrectable pulse, and it holds the number of bytes it changed.

States: IDLE, SCREEN, KICK, POLL, PICK, READ, WRITE, DONE, FAIL. Transitions:
- IDLE→SCREEN on an accepted start.
- SCREEN→DONE when the sector is erased or the syndrome is clean, otherwise SCREEN→KICK.
- KICK→POLL.
- POLL→DONE on code 0, POLL→FAIL on code 1 or on timeout, POLL→PICK on code 2 or 3, and POLL→POLL on any other code.
- PICK→READ on an in-range hit, PICK→PICK on a skip that is not the last error, PICK→DONE on a skip that is the last error.
- READ→WRITE.
- WRITE→PICK when more errors remain, WRITE→DONE after the last one.
- DONE→IDLE and FAIL→IDLE.

Top module: `ecc_loc_fixer`

## Requirements
- R1: When all ten stored ECC bytes equal 0xFF, the job ends with done, the count is 0, there is no location request and no RAM write.
- R2: When all syndrome bits are zero, the job ends with done and the count is 0, with no location request.
- R3: A non-zero syndrome on a non-erased sector gives exactly one one-cycle calc_go_o pulse, followed by polling of status_i. Code 0 gives done with count 0, code 1 gives fail, and codes 4 to 15 keep the block polling.
- R4: On code 2 or 3 the number of errors processed is err_cnt_i + 1, so 1 to 4.
- R5: Errors 0 and 1 take their location and value from loc_pair0_i and val_pair0_i, and errors 2 and 3 take them from loc_pair1_i and val_pair1_i. Even errors use bits [15:0] and odd errors use bits [31:16]. The location is bits [9:0] of that half and the XOR value is bits [7:0].
- R6: The byte index is 519 minus the 10-bit location. The value is XORed into that byte only when the index lies in 0..511. Any other result is skipped without counting.
- R7: Each correction is one read cycle followed by one write cycle to the same address, with read data returned one cycle after the read. Two errors on one byte therefore combine.
- R8: fixed_cnt_o equals the number of bytes written. It is cleared by an accepted start and held after the job ends.
- R9: busy_o rises in the cycle after an accepted start and stays high through the ending cycle. Start pulses seen while busy are ignored.
- R10: If the status code stays in the polling range for POLL_LIMIT cycles, the job ends with fail.
- R11: done_o and fail_o are one-cycle, mutually exclusive pulses. For an erased or clean sector, done_o is high in the second cycle after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Job start pulse |
| stored_ecc_i | input | 80 | Ten stored ECC bytes |
| syndrome_i | input | 128 | Four syndrome words |
| status_i | input | 4 | Engine status code |
| err_cnt_i | input | 2 | Error count minus one |
| loc_pair0_i | input | 32 | Locations for errors 0 and 1 |
| loc_pair1_i | input | 32 | Locations for errors 2 and 3 |
| val_pair0_i | input | 32 | Values for errors 0 and 1 |
| val_pair1_i | input | 32 | Values for errors 2 and 3 |
| calc_go_o | output | 1 | Request to the engine to compute locations |
| ram_addr_o | output | 9 | Sector RAM byte address |
| ram_rd_o | output | 1 | RAM read strobe |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the read |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job ended with correction or nothing to do |
| fail_o | output | 1 | Job ended as uncorrectable |
| fixed_cnt_o | output | 3 | Bytes corrected by the last job |

## Verification
For an erased or clean sector, the done pulse is due exactly two cycles after the edge that samples start. The bench counts falling edges from the start and checks that count directly. Jobs that poll end at a time set by the engine model, so the bench waits on done or fail within a bound and then checks the count, the pulse kind and the full sector contents against a shadow copy it updates itself. A RAM write becomes visible one edge after the WRITE state, and the sector is compared only after the job has ended.

// File: rtl/ecfx_pkg.sv
package ecfx_pkg;
    typedef enum logic [3:0] {
        FX_IDLE, FX_SCREEN, FX_KICK, FX_POLL, FX_PICK,
        FX_READ, FX_WRITE, FX_DONE, FX_FAIL
    } fx_state_t;

    typedef enum logic [1:0] {
        FK_CLEAN, FK_TOO_MANY, FK_READY, FK_WORKING
    } fx_kind_t;
endpackage

// File: rtl/ecfx_status_decode.sv
module ecfx_status_decode
    import ecfx_pkg::*;
(
    input  logic [3:0] code_i,
    output fx_kind_t   kind_o
);
    always_comb begin
        unique case (code_i)
            4'd0:       kind_o = FK_CLEAN;
            4'd1:       kind_o = FK_TOO_MANY;
            4'd2, 4'd3: kind_o = FK_READY;
            default:    kind_o = FK_WORKING;
        endcase
    end
endmodule

// File: rtl/ecfx_screen.sv
module ecfx_screen #(
    parameter int ECC_BYTES = 10,
    parameter int SYN_WORDS = 4
) (
    input  logic [ECC_BYTES*8-1:0]  stored_ecc_i,
    input  logic [SYN_WORDS*32-1:0] syndrome_i,
    output logic                    erased_o,
    output logic                    clean_o
);
    logic [ECC_BYTES-1:0] byte_ff;
    logic [SYN_WORDS-1:0] word_nz;

    for (genvar b = 0; b < ECC_BYTES; b++) begin : g_byte
        assign byte_ff[b] = &stored_ecc_i[8*b +: 8];
    end
    for (genvar w = 0; w < SYN_WORDS; w++) begin : g_word
        assign word_nz[w] = |syndrome_i[32*w +: 32];
    end

    assign erased_o = &byte_ff;
    assign clean_o  = ~|word_nz;
endmodule

// File: rtl/ecfx_loc_map.sv
module ecfx_loc_map #(
    parameter int DATA_BYTES  = 512,
    parameter int GUARD_BYTES = 7,
    localparam int IDXW = $clog2(DATA_BYTES)
) (
    input  logic [1:0]      err_idx_i,
    input  logic [31:0]     loc_pair0_i,
    input  logic [31:0]     loc_pair1_i,
    input  logic [31:0]     val_pair0_i,
    input  logic [31:0]     val_pair1_i,
    output logic [IDXW-1:0] byte_idx_o,
    output logic [7:0]      flip_o,
    output logic            hit_o
);
    localparam int LAST_POS = DATA_BYTES + GUARD_BYTES;

    logic [3:0][15:0] loc_half;
    logic [3:0][15:0] val_half;

    for (genvar k = 0; k < 4; k++) begin : g_slot
        if (k < 2) begin : g_lo
            assign loc_half[k] = loc_pair0_i[16*(k%2) +: 16];
            assign val_half[k] = val_pair0_i[16*(k%2) +: 16];
        end else begin : g_hi
            assign loc_half[k] = loc_pair1_i[16*(k%2) +: 16];
            assign val_half[k] = val_pair1_i[16*(k%2) +: 16];
        end
    end

    int pos;
    always_comb begin
        pos        = LAST_POS - int'(loc_half[err_idx_i][9:0]);
        hit_o      = (pos >= 0) && (pos < DATA_BYTES);
        byte_idx_o = IDXW'(pos);
        flip_o     = val_half[err_idx_i][7:0];
    end
endmodule

// File: rtl/ecc_loc_fixer.sv
module ecc_loc_fixer
    import ecfx_pkg::*;
#(
    parameter int DATA_BYTES  = 512,
    parameter int GUARD_BYTES = 7,
    parameter int ECC_BYTES   = 10,
    parameter int SYN_WORDS   = 4,
    parameter int POLL_LIMIT  = 64,
    localparam int IDXW = $clog2(DATA_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ECC_BYTES*8-1:0]  stored_ecc_i,
    input  logic [SYN_WORDS*32-1:0] syndrome_i,
    input  logic [3:0]              status_i,
    input  logic [1:0]              err_cnt_i,
    input  logic [31:0]             loc_pair0_i,
    input  logic [31:0]             loc_pair1_i,
    input  logic [31:0]             val_pair0_i,
    input  logic [31:0]             val_pair1_i,
    output logic                    calc_go_o,
    output logic [IDXW-1:0]         ram_addr_o,
    output logic                    ram_rd_o,
    output logic                    ram_wr_o,
    output logic [7:0]              ram_wdata_o,
    input  logic [7:0]              ram_rdata_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    fail_o,
    output logic [2:0]              fixed_cnt_o
);
    localparam int TW = $clog2(POLL_LIMIT + 1);

    fx_state_t       state_q, state_d;
    fx_kind_t        kind;
    logic            erased, clean;
    logic [IDXW-1:0] map_idx;
    logic [7:0]      map_flip;
    logic            map_hit;
    logic [1:0]      idx_q;
    logic [2:0]      total_q;
    logic [2:0]      fixed_q;
    logic [IDXW-1:0] addr_q;
    logic [7:0]      flip_q;
    logic [TW-1:0]   tmo_q;
    logic            last_err;
    logic            tmo_hit;

    ecfx_status_decode u_dec (.code_i(status_i), .kind_o(kind));

    ecfx_screen #(.ECC_BYTES(ECC_BYTES), .SYN_WORDS(SYN_WORDS)) u_scr (
        .stored_ecc_i(stored_ecc_i), .syndrome_i(syndrome_i),
        .erased_o(erased), .clean_o(clean)
    );

    ecfx_loc_map #(.DATA_BYTES(DATA_BYTES), .GUARD_BYTES(GUARD_BYTES)) u_map (
        .err_idx_i(idx_q),
        .loc_pair0_i(loc_pair0_i), .loc_pair1_i(loc_pair1_i),
        .val_pair0_i(val_pair0_i), .val_pair1_i(val_pair1_i),
        .byte_idx_o(map_idx), .flip_o(map_flip), .hit_o(map_hit)
    );

    assign last_err = ({1'b0, idx_q} == (total_q - 3'd1));
    assign tmo_hit  = (tmo_q == TW'(POLL_LIMIT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FX_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FX_IDLE:   if (start_i) state_d = FX_SCREEN;
            FX_SCREEN: state_d = (erased || clean) ? FX_DONE : FX_KICK;
            FX_KICK:   state_d = FX_POLL;
            FX_POLL: begin
                unique case (kind)
                    FK_CLEAN:    state_d = FX_DONE;
                    FK_TOO_MANY: state_d = FX_FAIL;
                    FK_READY:    state_d = FX_PICK;
                    FK_WORKING:  if (tmo_hit) state_d = FX_FAIL;
                endcase
            end
            FX_PICK: begin
                if (map_hit)       state_d = FX_READ;
                else if (last_err) state_d = FX_DONE;
            end
            FX_READ:  state_d = FX_WRITE;
            FX_WRITE: state_d = last_err ? FX_DONE : FX_PICK;
            FX_DONE, FX_FAIL: state_d = FX_IDLE;
            default:  state_d = FX_IDLE;
        endcase
    end

    // job datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            total_q <= '0;
            fixed_q <= '0;
            addr_q  <= '0;
            flip_q  <= '0;
            tmo_q   <= '0;
        end else begin
            unique case (state_q)
                FX_IDLE: if (start_i) fixed_q <= '0;
                FX_KICK: tmo_q <= '0;
                FX_POLL: begin
                    if (kind == FK_READY) begin
                        total_q <= {1'b0, err_cnt_i} + 3'd1;
                        idx_q   <= '0;
                    end else if (kind == FK_WORKING) begin
                        tmo_q <= tmo_q + TW'(1);
                    end
                end
                FX_PICK: begin
                    addr_q <= map_idx;
                    flip_q <= map_flip;
                    if (!map_hit) idx_q <= idx_q + 2'd1;
                end
                FX_WRITE: begin
                    fixed_q <= fixed_q + 3'd1;
                    idx_q   <= idx_q + 2'd1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != FX_IDLE);
        calc_go_o   = (state_q == FX_KICK);
        ram_rd_o    = (state_q == FX_READ);
        ram_wr_o    = (state_q == FX_WRITE);
        ram_addr_o  = addr_q;
        ram_wdata_o = ram_rdata_i ^ flip_q;
        done_o      = (state_q == FX_DONE);
        fail_o      = (state_q == FX_FAIL);
        fixed_cnt_o = fixed_q;
    end

    a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_o |-> ($past(ram_rd_o) && $stable(ram_addr_o)));
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd_o && ram_wr_o));
    a_r3_single_kick: assert property (@(posedge clk) disable iff (!rst_n)
        calc_go_o |=> !calc_go_o);
    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    a_r11_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    a_r11_end_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> !busy_o);
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fixed_cnt_o <= 3'd4));
endmodule

// File: tb/ecc_loc_fixer_tb.sv
module ecc_loc_fixer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [79:0]  stored_ecc_i = '0;
    logic [127:0] syndrome_i = '0;
    logic [3:0]   status_i = 4'hC;
    logic [1:0]   err_cnt_i = '0;
    logic [31:0]  loc_pair0_i = '0, loc_pair1_i = '0;
    logic [31:0]  val_pair0_i = '0, val_pair1_i = '0;
    logic         calc_go_o, ram_rd_o, ram_wr_o, busy_o, done_o, fail_o;
    logic [8:0]   ram_addr_o;
    logic [7:0]   ram_wdata_o, ram_rdata_i;
    logic [2:0]   fixed_cnt_o;

    int total = 0, bad = 0, kicks = 0, writes = 0;
    logic [7:0] mem [512];
    logic [7:0] shadow [512];
    logic [7:0] rd_q = '0;

    always #4 clk = ~clk;

    ecc_loc_fixer #(.POLL_LIMIT(20)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .stored_ecc_i(stored_ecc_i), .syndrome_i(syndrome_i),
        .status_i(status_i), .err_cnt_i(err_cnt_i),
        .loc_pair0_i(loc_pair0_i), .loc_pair1_i(loc_pair1_i),
        .val_pair0_i(val_pair0_i), .val_pair1_i(val_pair1_i),
        .calc_go_o(calc_go_o), .ram_addr_o(ram_addr_o),
        .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o),
        .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .fixed_cnt_o(fixed_cnt_o)
    );

    assign ram_rdata_i = rd_q;
    always @(posedge clk) begin
        if (ram_wr_o) begin mem[ram_addr_o] <= ram_wdata_o; writes <= writes + 1; end
        if (ram_rd_o) rd_q <= mem[ram_addr_o];
        if (calc_go_o) kicks <= kicks + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int diffs = 0;
        for (int i = 0; i < 512; i++) if (mem[i] !== shadow[i]) diffs++;
        chk(req, diffs, 0);
    endtask

    function automatic logic [15:0] at_byte(input int b);
        return 16'hFC00 | 16'(519 - b);
    endfunction

    task automatic run_job(output int lat, output bit gd, output bit gf);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        lat = 1;
        while (!(done_o || fail_o) && lat < 400) begin @(negedge clk); lat++; end
        gd = done_o; gf = fail_o;
    endtask

    task automatic engine(input logic [3:0] final_code);
        while (!calc_go_o) @(negedge clk);
        repeat (3) @(negedge clk);
        status_i = final_code;
    endtask

    task automatic t_erased;
        int lat; bit gd, gf; int k0, w0;
        k0 = kicks; w0 = writes;
        stored_ecc_i = {10{8'hFF}}; syndrome_i = 128'h1;
        run_job(lat, gd, gf);
        chk("R1 done", gd, 1);
        chk("R11 latency", lat, 2);
        chk("R1 count", fixed_cnt_o, 0);
        chk("R1 no kick", kicks - k0, 0);
        chk("R1 no write", writes - w0, 0);
    endtask

    task automatic t_clean;
        int lat; bit gd, gf; int k0;
        k0 = kicks;
        stored_ecc_i = {10{8'h12}}; syndrome_i = '0;
        run_job(lat, gd, gf);
        chk("R2 done", gd, 1);
        chk("R2 latency", lat, 2);
        chk("R2 no kick", kicks - k0, 0);
    endtask

    task automatic t_poll_end(input logic [3:0] code, input bit exp_fail);
        int lat; bit gd, gf; int k0;
        k0 = kicks;
        stored_ecc_i = {10{8'h34}}; syndrome_i = 128'h100;
        status_i = 4'hE;
        fork
            run_job(lat, gd, gf);
            engine(code);
        join
        chk("R3 one kick", kicks - k0, 1);
        chk("R3 outcome fail", gf, exp_fail);
        chk("R3 outcome done", gd, !exp_fail);
        if (!exp_fail) chk("R3 count", fixed_cnt_o, 0);
        status_i = 4'hC;
    endtask

    task automatic t_fix(input logic [3:0] code, input logic [1:0] cnt,
                         input logic [31:0] l0, l1, v0, v1, input int exp_cnt, input string req);
        int lat; bit gd, gf;
        stored_ecc_i = {10{8'h56}}; syndrome_i = 128'h1 << 70;
        err_cnt_i = cnt; loc_pair0_i = l0; loc_pair1_i = l1;
        val_pair0_i = v0; val_pair1_i = v1;
        status_i = 4'h9;
        fork
            run_job(lat, gd, gf);
            engine(code);
        join
        chk({req, " done"}, gd, 1);
        chk({req, " count"}, fixed_cnt_o, exp_cnt);
        @(negedge clk);
        chk_mem({req, " sector"});
        status_i = 4'hC;
    endtask

    task automatic t_timeout_and_ignore;
        int lat; bit gd, gf; int w0; bit busy_seen;
        w0 = writes;
        stored_ecc_i = {10{8'h78}}; syndrome_i = 128'h2;
        status_i = 4'h7;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!calc_go_o) @(negedge clk);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        busy_seen = busy_o;
        chk("R9 busy during job", busy_seen, 1);
        lat = 0;
        while (!(done_o || fail_o) && lat < 400) begin @(negedge clk); lat++; end
        chk("R10 timeout fail", fail_o, 1);
        chk("R10 bounded", (lat < 30) ? 1 : 0, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 start ignored", busy_o, 0);
        end
        chk("R9 no writes", writes - w0, 0);
        status_i = 4'hC;
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 37 + 11);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk("R9 reset busy", busy_o, 0);
        chk("R11 reset done", done_o, 0);
        chk("R11 reset fail", fail_o, 0);
        chk("R8 reset count", fixed_cnt_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle busy", busy_o, 0);

        t_erased();
        t_clean();
        t_poll_end(4'd0, 1'b0);
        t_poll_end(4'd1, 1'b1);

        // R5 R6 R8: four errors, one lands in the guard area
        shadow[10]  ^= 8'h21;
        shadow[300] ^= 8'h84;
        shadow[511] ^= 8'h3C;
        t_fix(4'd2, 2'd3,
              {at_byte(300), at_byte(10)}, {at_byte(511), 16'hFC03},
              {16'hAB84, 16'hAB21}, {16'hAB3C, 16'hAB55}, 3, "R5 R6");

        // R7: two hits on the same byte, third location beyond the codeword
        shadow[77] ^= 8'hFF;
        t_fix(4'd3, 2'd2,
              {at_byte(77), at_byte(77)}, {16'h0, 16'd1000},
              {16'h00F0, 16'h000F}, {16'h0, 16'h00AA}, 2, "R7");

        // R4: count field 0 processes only the first error
        shadow[0] ^= 8'h81;
        t_fix(4'd3, 2'd0,
              {at_byte(5), at_byte(0)}, {at_byte(6), at_byte(7)},
              {16'h0011, 16'h0081}, {16'h0022, 16'h0033}, 1, "R4");

        t_timeout_and_ignore();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule